// File: doc/BRIEF.md
# IDE Controller Register Window Router

This block sits behind the base-address decoder of a dual-channel IDE controller. For each IO access the decoder reports whether the address fell into one of the controller's windows, which window slot it hit and the byte offset inside that slot. The router adds the access size, the direction and the live PCI command register. From these it sends the access to exactly one of five register targets: primary command, primary control, secondary command, secondary control, or the bus-master register file.

Before forwarding, the router adjusts the offset for each target. The primary command offset is shifted right by a fixed amount. The primary control offset has a fixed constant added. The secondary offsets pass through unchanged. The 16-byte bus-master window is split into two 8-byte halves, one per channel, and the upper half is rebased to zero. Writes to the bus-master window are discarded while bus mastering is disabled in the command register. Illegal sizes and accesses outside every window are flagged as errors.

Every request, whether routed, dropped or in error, receives a single-cycle response one clock later, so a requester never waits.

Top module: `ide_win_router`

## Requirements
- R1: Each cycle with `req_valid` high produces `rsp_valid` high on the following cycle only. A cycle without a request produces `rsp_valid` low and all `tgt_*` outputs zero on the next cycle.
- R2: A legal access to slot s drives `tgt_strobe` bit s high and every other bit low. The slot encoding is 0 primary command, 1 primary control, 2 secondary command, 3 secondary control, 4 bus master. The access also forwards `tgt_write` and `tgt_size`. At most one strobe bit is ever high.
- R3: A primary command access forwards `req_offset >> IO_SHIFT` (default 1).
- R4: A primary control access forwards `req_offset + CTRL_OFS` (default 2).
- R5: Secondary command and secondary control accesses forward `req_offset` unchanged.
- R6: In the bus-master window, offsets 0 to 7 go to channel 0 (`tgt_chan`=0) unchanged. Offsets 8 to 15 go to channel 1 (`tgt_chan`=1) with 8 subtracted.
- R7: A bus-master write while `pci_cmd` bit 2 is 0 responds with `rsp_err`=0 and all strobes and `tgt_*` outputs zero. Bus-master reads are routed regardless of bit 2.
- R8: A size other than 1, 2 or 4 bytes sets `rsp_err` and leaves all strobes and `tgt_*` outputs zero.
- R9: An access misses and sets `rsp_err`, with no strobe, when any of these holds: `req_hit` is 0, the slot is above 4, or the offset is at or beyond the slot's window size. The window sizes are 8, 4, 8, 4 and 16 bytes for slots 0 to 4.
- R10: While `rst_n` is low at a clock edge, all outputs are zero on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_hit | input | 1 | Decoder matched some window |
| req_slot | input | 3 | Window slot reported by the decoder |
| req_offset | input | OFS_W | Byte offset within the slot |
| req_size | input | 3 | Access size in bytes |
| req_write | input | 1 | 1 for write, 0 for read |
| pci_cmd | input | 16 | PCI command register (bit 2 enables bus mastering) |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion carries an error |
| tgt_strobe | output | 5 | One-hot target select |
| tgt_write | output | 1 | Forwarded direction |
| tgt_size | output | 3 | Forwarded size |
| tgt_chan | output | 1 | Bus-master channel (0 primary, 1 secondary) |
| tgt_offset | output | OFS_W | Adjusted offset |

## Verification
The bench sweeps every combination of hit flag, slot (including the unused codes 5 to 7), offset, size code, direction and bus-master enable. It focuses on the offsets on either side of each window edge and of the bus-master split point. An off-by-one window check would accept offset 4 on a control slot or reject offset 15 on the bus-master slot. A wrong split would send offset 8 to the primary channel or leave it unrebased. A shift or add applied to the wrong slot would corrupt the primary or secondary offsets. A gate keyed on the wrong command bit, or on reads, would pass disabled bus-master writes or swallow reads. Idle cycles between requests expose a response that lingers for more than one cycle.

// File: rtl/ide_rt_pkg.sv
// Shared constants for the IDE window router.
// Assumes five decoder slots in the fixed order used by the controller.
package ide_rt_pkg;
    localparam int NUM_SLOTS   = 5;
    localparam int SLOT_W      = 3;
    localparam int STROBE_W    = NUM_SLOTS;
    localparam int SIZE_W      = 3;
    localparam int CMD_W       = 16;
    localparam int BM_EN_BIT   = 2;
    localparam int CMD_WIN     = 8;
    localparam int CTL_WIN     = 4;
    localparam int BM_BLK      = 8;
    localparam int BM_WIN      = 2 * BM_BLK;

    typedef enum logic [SLOT_W-1:0] {
        SLOT_PCMD = 3'd0,
        SLOT_PCTL = 3'd1,
        SLOT_SCMD = 3'd2,
        SLOT_SCTL = 3'd3,
        SLOT_BM   = 3'd4
    } slot_e;

    // Window size in bytes for a slot index.
    function automatic int win_bytes(input int idx);
        case (idx)
            0:       return CMD_WIN;
            1:       return CTL_WIN;
            2:       return CMD_WIN;
            3:       return CTL_WIN;
            4:       return BM_WIN;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/ide_rt_legal.sv
// Legality check: decodes the slot into a one-hot hit vector qualified by
// the window bound of each slot, and checks the access size.
// Assumes OFS_W is wide enough to hold the largest window size.
module ide_rt_legal #(
    parameter int OFS_W = 6
) (
    input  logic                                 hit,
    input  logic [ide_rt_pkg::SLOT_W-1:0]        slot,
    input  logic [OFS_W-1:0]                     offset,
    input  logic [ide_rt_pkg::SIZE_W-1:0]        size,
    output logic [ide_rt_pkg::STROBE_W-1:0]      slot_ok,
    output logic                                 size_ok
);
    // One comparator per slot, each with its own window bound.
    for (genvar i = 0; i < ide_rt_pkg::NUM_SLOTS; i++) begin : g_slot
        localparam logic [OFS_W:0] LIM = (OFS_W+1)'(ide_rt_pkg::win_bytes(i));
        localparam logic [ide_rt_pkg::SLOT_W-1:0] IDX = ide_rt_pkg::SLOT_W'(i);
        assign slot_ok[i] = hit && (slot == IDX) && ({1'b0, offset} < LIM);
    end

    // Only byte, half-word and word accesses are legal.
    always_comb begin
        size_ok = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
    end
endmodule

// File: rtl/ide_rt_remap.sv
// Offset adjustment per target: a shift on primary command, an additive
// offset on primary control, a pass-through on secondary, and a split
// with rebase on the bus-master file.
// Assumes CTRL_OFS plus the control window fits in OFS_W bits.
module ide_rt_remap #(
    parameter int OFS_W    = 6,
    parameter int IO_SHIFT = 1,
    parameter int CTRL_OFS = 2
) (
    input  logic [ide_rt_pkg::STROBE_W-1:0] slot_ok,
    input  logic [OFS_W-1:0]                offset,
    output logic [OFS_W-1:0]                fwd_offset,
    output logic                            bm_chan
);
    localparam logic [OFS_W-1:0] BLK = OFS_W'(ide_rt_pkg::BM_BLK);
    localparam logic [OFS_W-1:0] ADD = OFS_W'(CTRL_OFS);

    logic upper_half;

    // Bus-master split point between the two channel blocks.
    always_comb begin
        upper_half = (offset >= BLK);
    end

    // Select the adjusted offset for whichever slot is hit.
    always_comb begin
        fwd_offset = '0;
        bm_chan    = 1'b0;
        if (slot_ok[ide_rt_pkg::SLOT_PCMD]) begin
            fwd_offset = offset >> IO_SHIFT;
        end else if (slot_ok[ide_rt_pkg::SLOT_PCTL]) begin
            fwd_offset = offset + ADD;
        end else if (slot_ok[ide_rt_pkg::SLOT_SCMD] || slot_ok[ide_rt_pkg::SLOT_SCTL]) begin
            fwd_offset = offset;
        end else if (slot_ok[ide_rt_pkg::SLOT_BM]) begin
            bm_chan    = upper_half;
            fwd_offset = upper_half ? (offset - BLK) : offset;
        end
    end
endmodule

// File: rtl/ide_rt_gate.sv
// Final gating: removes strobes on an illegal size and drops bus-master
// writes while bus mastering is disabled. Reports an error when the
// access is illegal.
// Assumes slot_ok is one-hot or zero.
module ide_rt_gate (
    input  logic [ide_rt_pkg::STROBE_W-1:0] slot_ok,
    input  logic                            size_ok,
    input  logic                            write,
    input  logic                            bm_enable,
    output logic [ide_rt_pkg::STROBE_W-1:0] strobe,
    output logic                            err
);
    logic any_slot;
    logic drop_bm;

    // Error when the access is outside all windows or badly sized.
    always_comb begin
        any_slot = |slot_ok;
        err      = !any_slot || !size_ok;
    end

    // Suppress the bus-master strobe for writes with mastering off.
    always_comb begin
        drop_bm = write && !bm_enable;
        strobe  = size_ok ? slot_ok : '0;
        if (drop_bm) begin
            strobe[ide_rt_pkg::SLOT_BM] = 1'b0;
        end
    end
endmodule

// File: rtl/ide_win_router.sv
// IDE register window router top. Combines the legality check, offset
// remap and gating, and registers the outcome into a one-cycle response.
// Assumes at most one request per cycle. Every request completes on the
// next cycle.
module ide_win_router #(
    parameter int OFS_W    = 6,
    parameter int IO_SHIFT = 1,
    parameter int CTRL_OFS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_hit,
    input  logic [2:0]        req_slot,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic [2:0]        req_size,
    input  logic              req_write,
    input  logic [15:0]       pci_cmd,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [4:0]        tgt_strobe,
    output logic              tgt_write,
    output logic [2:0]        tgt_size,
    output logic              tgt_chan,
    output logic [OFS_W-1:0]  tgt_offset
);
    import ide_rt_pkg::*;

    logic [STROBE_W-1:0] slot_ok;
    logic                size_ok;
    logic [OFS_W-1:0]    fwd_offset;
    logic                bm_chan;
    logic [STROBE_W-1:0] strobe_c;
    logic                err_c;
    logic                routed;

    ide_rt_legal #(.OFS_W(OFS_W)) u_legal (
        .hit     (req_hit),
        .slot    (req_slot),
        .offset  (req_offset),
        .size    (req_size),
        .slot_ok (slot_ok),
        .size_ok (size_ok)
    );

    ide_rt_remap #(.OFS_W(OFS_W), .IO_SHIFT(IO_SHIFT), .CTRL_OFS(CTRL_OFS)) u_remap (
        .slot_ok    (slot_ok),
        .offset     (req_offset),
        .fwd_offset (fwd_offset),
        .bm_chan    (bm_chan)
    );

    ide_rt_gate u_gate (
        .slot_ok   (slot_ok),
        .size_ok   (size_ok),
        .write     (req_write),
        .bm_enable (pci_cmd[BM_EN_BIT]),
        .strobe    (strobe_c),
        .err       (err_c)
    );

    // True when the access actually reaches a target this cycle.
    always_comb begin
        routed = req_valid && (|strobe_c);
    end

    // Register the response and forwarded fields; zero everything not routed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_err    <= 1'b0;
            tgt_strobe <= '0;
            tgt_write  <= 1'b0;
            tgt_size   <= '0;
            tgt_chan   <= 1'b0;
            tgt_offset <= '0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_err    <= req_valid && err_c;
            tgt_strobe <= routed ? strobe_c : '0;
            tgt_write  <= routed && req_write;
            tgt_size   <= routed ? req_size : '0;
            tgt_chan   <= routed && bm_chan;
            tgt_offset <= routed ? fwd_offset : '0;
        end
    end
endmodule

// File: rtl/ide_win_router_chk.sv
// Property checker for the router, bound onto every instance.
module ide_win_router_chk #(
    parameter int OFS_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_hit,
    input logic [2:0]        req_slot,
    input logic [OFS_W-1:0]  req_offset,
    input logic [2:0]        req_size,
    input logic              req_write,
    input logic [15:0]       pci_cmd,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [4:0]        tgt_strobe,
    input logic [OFS_W-1:0]  tgt_offset
);
    logic bad_size;
    logic sec_legal;

    // Helper terms computed from the request side only.
    always_comb begin
        bad_size  = !((req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4));
        sec_legal = req_hit && !bad_size &&
                    (((req_slot == 3'd2) && (req_offset < OFS_W'(8))) ||
                     ((req_slot == 3'd3) && (req_offset < OFS_W'(4))));
    end

    assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_rsp_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && tgt_strobe == 5'd0));
    assert_strobe_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_strobe));
    assert_sec_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sec_legal) |=> (tgt_offset == $past(req_offset)));
    assert_bm_write_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_slot == 3'd4 && !pci_cmd[2]) |=> !tgt_strobe[4]);
    assert_bad_size_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bad_size) |=> (rsp_err && tgt_strobe == 5'd0));
    assert_miss_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_hit) |=> (rsp_err && tgt_strobe == 5'd0));
    assert_err_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (tgt_strobe == 5'd0));
endmodule

bind ide_win_router ide_win_router_chk #(.OFS_W(OFS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_hit    (req_hit),
    .req_slot   (req_slot),
    .req_offset (req_offset),
    .req_size   (req_size),
    .req_write  (req_write),
    .pci_cmd    (pci_cmd),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .tgt_strobe (tgt_strobe),
    .tgt_offset (tgt_offset)
);

// File: tb/tb_ide_win_router.sv
module tb_ide_win_router;
    localparam int CLK_PERIOD = 10;
    localparam int OFS_W      = 6;
    localparam int IO_SHIFT   = 1;
    localparam int CTRL_OFS   = 2;
    localparam int WATCHDOG   = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_hit = 1'b0;
    logic [2:0]       req_slot = '0;
    logic [OFS_W-1:0] req_offset = '0;
    logic [2:0]       req_size = '0;
    logic             req_write = 1'b0;
    logic [15:0]      pci_cmd = '0;
    logic             rsp_valid, rsp_err, tgt_write, tgt_chan;
    logic [4:0]       tgt_strobe;
    logic [2:0]       tgt_size;
    logic [OFS_W-1:0] tgt_offset;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    ide_win_router #(.OFS_W(OFS_W), .IO_SHIFT(IO_SHIFT), .CTRL_OFS(CTRL_OFS)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hit(req_hit),
        .req_slot(req_slot), .req_offset(req_offset), .req_size(req_size),
        .req_write(req_write), .pci_cmd(pci_cmd), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .tgt_strobe(tgt_strobe), .tgt_write(tgt_write),
        .tgt_size(tgt_size), .tgt_chan(tgt_chan), .tgt_offset(tgt_offset)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Packed view of all outputs: valid, err, strobe, write, size, chan, offset.
    function automatic logic [12+OFS_W:0] outs();
        return {rsp_valid, rsp_err, tgt_strobe, tgt_write, tgt_size, tgt_chan, tgt_offset};
    endfunction

    task automatic check(input string tag, input logic [12+OFS_W:0] act, input logic [12+OFS_W:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (slot %0d off %0d size %0d wr %0b bm %0b hit %0b)",
                     tag, act, exp, req_slot, req_offset, req_size, req_write, pci_cmd[2], req_hit);
        end
    endtask

    // Issue one request, check its response, then check the idle cycle after.
    task automatic do_req(input bit hit, input int slot, input int off, input int size,
                          input bit wr, input bit bm);
        int  win;
        bit  legal, szok;
        logic [4:0] e_strobe;
        logic [OFS_W-1:0] e_off;
        logic e_chan, e_err;
        string tag;
        @(negedge clk);
        req_valid  = 1'b1;
        req_hit    = hit;
        req_slot   = 3'(slot);
        req_offset = OFS_W'(off);
        req_size   = 3'(size);
        req_write  = wr;
        pci_cmd    = bm ? 16'h0005 : 16'h0001;
        case (slot)
            0: win = 8; 1: win = 4; 2: win = 8; 3: win = 4; 4: win = 16;
            default: win = 0;
        endcase
        szok  = (size == 1) || (size == 2) || (size == 4);
        legal = hit && (off < win);
        e_strobe = '0; e_off = '0; e_chan = 1'b0; e_err = 1'b0;
        if (!szok) begin
            e_err = 1'b1; tag = "R8";
        end else if (!legal) begin
            e_err = 1'b1; tag = "R9";
        end else if (slot == 4 && wr && !bm) begin
            tag = "R7 drop";
        end else begin
            e_strobe = 5'(1 << slot);
            case (slot)
                0: begin e_off = OFS_W'(off >> IO_SHIFT); tag = "R2/R3"; end
                1: begin e_off = OFS_W'(off + CTRL_OFS); tag = "R2/R4"; end
                2, 3: begin e_off = OFS_W'(off); tag = "R2/R5"; end
                default: begin
                    e_chan = (off >= 8);
                    e_off  = OFS_W'(off >= 8 ? off - 8 : off);
                    tag    = (wr ? "R6/R7 write" : "R6/R7 read");
                end
            endcase
        end
        @(negedge clk);
        if (e_strobe != 0)
            check(tag, outs(), {1'b1, e_err, e_strobe, wr, 3'(size), e_chan, e_off});
        else
            check(tag, outs(), {1'b1, e_err, 5'd0, 1'b0, 3'd0, 1'b0, {OFS_W{1'b0}}});
        req_valid = 1'b0;
        @(negedge clk);
        check("R1 idle", outs(), '0);
    endtask

    initial begin
        while (!done && cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        // R10: reset holds all outputs at zero even with a request present.
        req_valid = 1'b1;
        req_hit   = 1'b1;
        req_size  = 3'd4;
        repeat (3) @(negedge clk);
        check("R10 reset", outs(), '0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after reset", outs(), '0);

        // Exhaustive sweep of the small configuration.
        for (int h = 0; h < 2; h++)
            for (int s = 0; s < 8; s++)
                for (int k = 0; k < 22; k++)
                    for (int z = 0; z < 8; z++)
                        for (int w = 0; w < 2; w++)
                            for (int b = 0; b < 2; b++)
                                do_req(h[0], s, (k == 21) ? 63 : k, z, w[0], b[0]);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule